// File: doc/BRIEF.md
# Activity-Triggered Standby Controller

This block watches a bus of monitored inputs and decides whether a downstream device runs in an active state or rests in a low-power standby state. The inputs are sampled into the clock domain. Any bit that differs between two consecutive samples counts as activity. Activity seen during standby wakes the device and opens an active window of a fixed number of clock cycles. Further activity inside the window restarts the window. When the window expires with no new activity, the block falls back to standby.

The window length is the product of two parameters: a base unit in cycles, and a small multiple of that unit (normally 2 to 4). A static configuration input, `keep_awake`, pins the block in the active state for as long as it is high. Held low, which is the power-saving setting, it allows standby.

The controller has three states:
- `ST_SLEEP`: the device is in standby.
- `ST_AWAKE`: the window is running.
- `ST_PINNED`: the configuration input holds the device active.

The named transitions are:
- wake (SLEEP→AWAKE, on activity)
- pin (SLEEP→PINNED or AWAKE→PINNED, when `keep_awake` is high)
- retrigger (AWAKE→AWAKE, on activity)
- expire (AWAKE→SLEEP, when the count runs out)
- release (PINNED→AWAKE, when `keep_awake` falls)

Top module: `act_standby_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `active_o`=0, `wake_o`=0 and `hold_o`=1.
- R2: When an input change is present before clock edge k and the block is in standby, `active_o` and `wake_o` are high after edge k+1.
- R3: `wake_o` is high for exactly one cycle on each entry from standby into the active state. It never rises on a retrigger.
- R4: With no further activity, `active_o` stays high for exactly WIN = UNIT_CYCLES*WIN_UNITS cycles and then returns to 0.
- R5: A change detected while active restarts the window. `active_o` then stays high for WIN cycles counted from the retrigger.
- R6: `hold_o` is always the inverse of `active_o`. In standby with unchanging inputs, all outputs stay constant.
- R7: While `keep_awake`=1 the block stays active on every cycle, whatever the inputs do. If `keep_awake` rises during standby, one wake strobe is produced, after the first clock edge that samples it.
- R8: The first input sample after reset is taken as the baseline, so a nonzero input at reset causes no wake.
- R9: A change on any bit counts as activity, including the most significant bit. A change on several bits at once counts as a single activity event.
- R10: After `keep_awake` falls (sampled at edge j), `active_o` stays high through edge j+WIN-1 and is 0 after edge j+WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_in | input | WIDTH | Monitored input bus |
| keep_awake | input | 1 | 1 = stay active at all times; 0 = standby allowed |
| active_o | output | 1 | 1 = active, 0 = standby |
| wake_o | output | 1 | One-cycle strobe on each entry into the active state |
| hold_o | output | 1 | Hold enable for downstream output registers (high in standby) |

## Verification
The bench checks that a nonzero bus value present during reset is taken as a baseline. A design that compared against a cleared register would wake spuriously. It counts the window length cycle by cycle on both sides of expiry, so an off-by-one counter shows up as an active state that is one cycle too long or too short. It retriggers inside a window with a multi-bit change and checks that the window is extended and that no second wake strobe appears. A design that strobed on every change, or that ignored activity while awake, fails here. Finally, it toggles the bus while `keep_awake` is held, then releases `keep_awake` and checks that a full fresh window follows rather than an immediate drop to standby.

// File: rtl/asc_pkg.sv
package asc_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_AWAKE  = 2'd1,
        ST_PINNED = 2'd2
    } asc_state_e;
endpackage

// File: rtl/asc_activity.sv
// Samples the monitored bus and flags any bit difference between two
// consecutive samples, once both samples are valid after reset.
module asc_activity #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] mon_in,
    output logic             act_o
);
    logic [WIDTH-1:0] samp_q;
    logic [WIDTH-1:0] prev_q;
    logic             samp_v;
    logic             prev_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
            samp_v <= 1'b0;
            prev_v <= 1'b0;
        end else begin
            samp_q <= mon_in;
            prev_q <= samp_q;
            samp_v <= 1'b1;
            prev_v <= samp_v;
        end
    end

    assign act_o = samp_v && prev_v && (|(samp_q ^ prev_q));
endmodule

// File: rtl/asc_window.sv
// Down-counter for the active window; load restarts it at WIN-1.
module asc_window #(
    parameter int WIN = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] TOP = CW'(WIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= TOP;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asc_fsm.sv
module asc_fsm
    import asc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic activity_i,
    input  logic keep_i,
    input  logic done_i,
    output logic load_o,
    output logic active_o,
    output logic wake_o
);
    asc_state_e state_q;
    asc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (keep_i)          state_d = ST_PINNED;
                else if (activity_i) state_d = ST_AWAKE;
            end
            ST_AWAKE: begin
                if (keep_i)          state_d = ST_PINNED;
                else if (activity_i) state_d = ST_AWAKE;
                else if (done_i)     state_d = ST_SLEEP;
            end
            ST_PINNED: begin
                if (!keep_i)         state_d = ST_AWAKE;
            end
            default:                 state_d = ST_SLEEP;
        endcase
    end

    assign load_o = activity_i || (state_q == ST_PINNED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            wake_o   <= 1'b0;
        end else begin
            active_o <= (state_d != ST_SLEEP);
            wake_o   <= (state_q == ST_SLEEP) && (state_d != ST_SLEEP);
        end
    end
endmodule

// File: rtl/act_standby_ctrl.sv
module act_standby_ctrl #(
    parameter int WIDTH       = 8,
    parameter int UNIT_CYCLES = 4,
    parameter int WIN_UNITS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] mon_in,
    input  logic             keep_awake,
    output logic             active_o,
    output logic             wake_o,
    output logic             hold_o
);
    localparam int WIN = UNIT_CYCLES * WIN_UNITS;

    logic act_w;
    logic load_w;
    logic done_w;
    logic active_w;
    logic wake_w;

    asc_activity #(.WIDTH(WIDTH)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .mon_in (mon_in),
        .act_o  (act_w)
    );

    asc_window #(.WIN(WIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .done_o (done_w)
    );

    asc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .activity_i (act_w),
        .keep_i     (keep_awake),
        .done_i     (done_w),
        .load_o     (load_w),
        .active_o   (active_w),
        .wake_o     (wake_w)
    );

    assign active_o = active_w;
    assign wake_o   = wake_w;
    assign hold_o   = !active_w;
endmodule

// File: rtl/asc_checker.sv
module asc_checker (
    input logic clk,
    input logic rst_n,
    input logic keep_awake,
    input logic active_o,
    input logic wake_o,
    input logic hold_o
);
    // R3
    wake_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> active_o);

    // R3
    wake_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R2
    rise_has_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> wake_o);

    // R7
    pinned_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_awake && active_o) |=> active_o);

    // R4
    fall_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> !$past(keep_awake));

    // R6
    hold_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $fell(active_o));
endmodule

bind act_standby_ctrl asc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .keep_awake (keep_awake),
    .active_o   (active_o),
    .wake_o     (wake_o),
    .hold_o     (hold_o)
);

// File: tb/sim_act_standby_ctrl.sv
`timescale 1ns/1ps
module sim_act_standby_ctrl;
    localparam int W   = 8;
    localparam int UC  = 4;
    localparam int WU  = 3;
    localparam int WIN = UC * WU;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] mon_in = 8'hA5;
    logic         keep = 1'b0;
    logic         active_o, wake_o, hold_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    act_standby_ctrl #(.WIDTH(W), .UNIT_CYCLES(UC), .WIN_UNITS(WU)) u0 (
        .clk(clk), .rst_n(rst_n), .mon_in(mon_in), .keep_awake(keep),
        .active_o(active_o), .wake_o(wake_o), .hold_o(hold_o)
    );

    typedef struct packed { logic act; logic wake; } exp_t;
    exp_t sbq[$];

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model: builds the expected outputs from the requirements.
    int           m_n = 0;
    logic [W-1:0] m_last = '0;
    bit           m_chg = 0, m_pin = 0, m_act = 0;
    int           m_rem = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_chg = 0; m_pin = 0; m_rem = 0; m_act = 0;
        end else begin
            bit na, nw;
            exp_t e;
            if (keep) begin
                m_rem = WIN; m_pin = 1;
            end else if (m_chg || m_pin) begin
                m_rem = WIN; m_pin = 0;
            end else if (m_rem > 0) begin
                m_rem--;
            end
            na = (m_rem > 0);
            nw = na && !m_act;
            m_act = na;
            m_chg = (m_n >= 1) && (mon_in != m_last);
            m_last = mon_in;
            if (m_n < 2) m_n++;
            e.act = na; e.wake = nw;
            sbq.push_back(e);
        end
    end

    // Monitor: pops expected items and compares them with the outputs.
    always @(negedge clk) begin
        if (!done && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check("R4 scoreboard active", active_o, e.act);
            check("R3 scoreboard wake", wake_o, e.wake);
            check("R6 scoreboard hold", hold_o, !e.act);
        end
    end

    initial begin
        tick(3);
        check("R1 reset active", active_o, 1'b0);
        check("R1 reset wake", wake_o, 1'b0);
        check("R1 reset hold", hold_o, 1'b1);
        rst_n = 1'b1;
        tick(1);
        check("R1 after release active", active_o, 1'b0);
        tick(5);
        check("R8 no false wake", active_o, 1'b0);
        check("R6 hold in standby", hold_o, 1'b1);

        // single-bit wake, then full window
        mon_in = mon_in ^ 8'h01;
        tick(1);
        check("R2 not yet active", active_o, 1'b0);
        tick(1);
        check("R2 active", active_o, 1'b1);
        check("R2 wake", wake_o, 1'b1);
        tick(1);
        check("R3 wake one cycle", wake_o, 1'b0);
        tick(WIN - 2);
        check("R4 last active cycle", active_o, 1'b1);
        tick(1);
        check("R4 expired", active_o, 1'b0);
        check("R6 hold back", hold_o, 1'b1);

        // MSB wake, multi-bit retrigger
        mon_in = mon_in ^ 8'h80;
        tick(2);
        check("R9 msb wakes", active_o, 1'b1);
        check("R9 msb wake strobe", wake_o, 1'b1);
        tick(2);
        mon_in = mon_in ^ 8'h3C;
        tick(2);
        check("R3 no strobe on retrigger", wake_o, 1'b0);
        tick(WIN - 1);
        check("R5 window extended", active_o, 1'b1);
        tick(1);
        check("R5 extended window ends", active_o, 1'b0);

        tick(20);
        check("R6 standby stable active", active_o, 1'b0);
        check("R6 standby stable wake", wake_o, 1'b0);

        // pinned active
        keep = 1'b1;
        tick(1);
        check("R7 pinned active", active_o, 1'b1);
        check("R7 pinned wake", wake_o, 1'b1);
        tick(1);
        check("R7 single wake", wake_o, 1'b0);
        for (int i = 0; i < 10; i++) begin
            mon_in = mon_in + 8'h11;
            tick(3);
        end
        tick(WIN + 5);
        check("R7 still active", active_o, 1'b1);
        keep = 1'b0;
        tick(1);
        check("R10 released still active", active_o, 1'b1);
        tick(WIN - 1);
        check("R10 window after release", active_o, 1'b1);
        tick(1);
        check("R10 standby after window", active_o, 1'b0);
        tick(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule